// File: doc/BRIEF.md
# Display Pixel Write Packer

The packer sits between a parallel host write bus and a display data memory. The host writes colour data as bytes or as 16-bit words. The block gathers those writes into whole pixels. Each finished pixel leaves as a single memory write, carrying a 16-bit 5-6-5 value and an address that counts up by itself.

Three colour formats are accepted. Two are 12-bit layouts, called A and B. The third is native 5-6-5. Every 12-bit pixel is widened to 5-6-5 by copying its top bits into the new low bits.

The block tracks the write phase within each pixel group and throws away dummy bits. The hardest case is format A on the byte bus: three bytes carry two pixels, and the second pixel starts in the middle of the second byte.

A host write is taken only while the memory-write command input is high. A rising edge of that command sends the address pointer back to zero.

Top module: `pix_pack_top`

## Requirements
- R1: While rst_ni is low and after it is released, mem_we_o is 0 and mem_addr_o is 0. The first write taken after reset is phase 0 of a new group.
- R2: With bus16_i=1, every accepted host write commits exactly one pixel, in any format.
- R3: Format A (color_mode_i=0) with bus16_i=0 carries two pixels in three bytes. Byte 1 is {R1,G1}, byte 2 is {B1,R2} and byte 3 is {G2,B2}, with the high nibble first in each byte. Pixel 1 commits on byte 2 and pixel 2 commits on byte 3. Byte 1 commits nothing.
- R4: Format A with bus16_i=1 reads R from [15:12], G from [11:8] and B from [7:4]. Bits [3:0] are ignored.
- R5: Format B (color_mode_i=1) with bus16_i=0 takes two bytes. Byte 1 holds R in [3:0], and its [7:4] is ignored. Byte 2 holds G in [7:4] and B in [3:0]. The pixel commits on byte 2 only.
- R6: Format B with bus16_i=1 ignores [15:12] and reads R from [11:8], G from [7:4] and B from [3:0].
- R7: color_mode_i=2 or 3 selects 5-6-5. On the byte bus, byte 1 becomes pixel bits [15:8] and byte 2 becomes bits [7:0], and the pixel commits on byte 2. On the 16-bit bus the word is the pixel.
- R8: A 12-bit pixel with 4-bit channels r, g, b is stored as {r, r[3], g, g[3:2], b, b[3]}.
- R9: A rising edge of mem_wr_cmd_i sets the pointer to 0. Each commit presents the pointer on mem_addr_o and then adds one to it. mem_addr_o holds its value between commits.
- R10: A host write while mem_wr_cmd_i=0 has no effect. While mem_wr_cmd_i=0 the phase is held at 0, so a partial group is dropped.
- R11: If an accepted write carries a mode or bus width different from the previous accepted write, that write is phase 0 of a new group.
- R12: mem_we_o is high for exactly the one cycle after the clock edge that takes a committing write, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_wr_cmd_i | input | 1 | Memory-write command is active |
| color_mode_i | input | 2 | 0 = format A, 1 = format B, 2 or 3 = 5-6-5 |
| bus16_i | input | 1 | 1 = 16-bit bus, 0 = byte bus on [7:0] |
| host_we_i | input | 1 | Host write strobe, one write per cycle high |
| host_data_i | input | 16 | Host write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | 16 | Pixel in 5-6-5 |

## Verification
The awkward states are partial groups that get cut off. Examples are a format-A group stopped after its first or second byte, by a drop of the command or by a change of mode or bus width. Another is a command edge that lands in the same cycle as a host write.

Directed sequences reach each of these deliberately: partial bytes are sent, then the command is pulsed or the format is switched before the group closes. A long random run then changes mode, width and command at a low rate between bursts of writes. This reaches every phase for every kind of cut. A behavioural model tracks the expected strobe, address and data on every cycle.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

  typedef enum logic [1:0] {
    FMT_A12  = 2'd0,
    FMT_B12  = 2'd1,
    FMT_565  = 2'd2,
    FMT_565X = 2'd3
  } fmt_e;

  localparam int unsigned PIX_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned PHASE_W = 2;

  typedef struct packed {
    fmt_e fmt;
    logic wide;
  } cfg_t;

  function automatic logic [PIX_W-1:0] widen12(input logic [NIB_W-1:0] r,
                                               input logic [NIB_W-1:0] g,
                                               input logic [NIB_W-1:0] b);
    return {r, r[NIB_W-1], g, g[NIB_W-1 -: 2], b, b[NIB_W-1]};
  endfunction

  function automatic logic is_565(input fmt_e f);
    return (f == FMT_565) || (f == FMT_565X);
  endfunction

endpackage

// File: rtl/pix_phase_ctrl.sv
module pix_phase_ctrl
  import pix_pack_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_i,
  input  logic               we_i,
  input  cfg_t               cfg_i,
  output logic               acc_o,
  output logic               restart_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               commit_o
);

  logic [PHASE_W-1:0] phase_q, phase_d, last_phase;
  cfg_t               cfg_q;

  assign acc_o     = we_i & cmd_i;
  assign restart_o = (cfg_i != cfg_q);
  assign phase_o   = restart_o ? '0 : phase_q;

  // format A on bytes runs three phases, every other byte-bus format two
  assign last_phase = (cfg_i.fmt == FMT_A12) ? PHASE_W'(2) : PHASE_W'(1);

  // on the byte bus every phase after the first closes a pixel
  assign commit_o = acc_o & (cfg_i.wide | (phase_o != '0));

  always_comb begin
    phase_d = phase_q;
    if (!cmd_i) begin
      phase_d = '0;
    end else if (acc_o) begin
      if (cfg_i.wide || phase_o == last_phase) phase_d = '0;
      else                                     phase_d = phase_o + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cfg_q   <= '{fmt: FMT_A12, wide: 1'b0};
    end else begin
      phase_q <= phase_d;
      if (acc_o) cfg_q <= cfg_i;
    end
  end

endmodule

// File: rtl/pix_assembler.sv
module pix_assembler
  import pix_pack_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_i,
  input  logic               acc_i,
  input  logic               restart_i,
  input  cfg_t               cfg_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PIX_W-1:0]   data_i,
  output logic [PIX_W-1:0]   pix_o
);

  logic [BYTE_W-1:0] prev_q;
  logic [BYTE_W-1:0] cur;
  logic [NIB_W-1:0]  r, g, b;

  assign cur = data_i[BYTE_W-1:0];

  // prev_q keeps the byte before the current one; format A phase 2 uses its low nibble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               prev_q <= '0;
    else if (!cmd_i)           prev_q <= '0;
    else if (acc_i && !cfg_i.wide) prev_q <= cur;
    else if (acc_i && restart_i)   prev_q <= '0;
  end

  always_comb begin
    r = '0;
    g = '0;
    b = '0;
    if (cfg_i.wide) begin
      unique case (cfg_i.fmt)
        FMT_A12: begin r = data_i[15:12]; g = data_i[11:8]; b = data_i[7:4]; end
        FMT_B12: begin r = data_i[11:8];  g = data_i[7:4];  b = data_i[3:0]; end
        default: ;
      endcase
    end else begin
      unique case (cfg_i.fmt)
        FMT_A12: begin
          if (phase_i == PHASE_W'(2)) begin
            r = prev_q[3:0]; g = cur[7:4]; b = cur[3:0];
          end else begin
            r = prev_q[7:4]; g = prev_q[3:0]; b = cur[7:4];
          end
        end
        FMT_B12: begin r = prev_q[3:0]; g = cur[7:4]; b = cur[3:0]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (is_565(cfg_i.fmt)) pix_o = cfg_i.wide ? data_i : {prev_q, cur};
    else                   pix_o = widen12(r, g, b);
  end

endmodule

// File: rtl/pix_commit.sv
module pix_commit
  import pix_pack_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              commit_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PIX_W-1:0]  data_o
);

  logic              cmd_q;
  logic [ADDR_W-1:0] ptr_q, ptr_cur;

  assign ptr_cur = (cmd_i && !cmd_q) ? '0 : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      ptr_q  <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      cmd_q <= cmd_i;
      we_o  <= commit_i;
      ptr_q <= ptr_cur + ADDR_W'(commit_i);
      if (commit_i) begin
        addr_o <= ptr_cur;
        data_o <= pix_i;
      end
    end
  end

endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
  import pix_pack_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_wr_cmd_i,
  input  logic [1:0]        color_mode_i,
  input  logic              bus16_i,
  input  logic              host_we_i,
  input  logic [15:0]       host_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_data_o
);

  cfg_t               cfg;
  logic               acc, restart, commit;
  logic [PHASE_W-1:0] phase;
  logic [PIX_W-1:0]   pix;

  assign cfg.fmt  = fmt_e'(color_mode_i);
  assign cfg.wide = bus16_i;

  pix_phase_ctrl u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (mem_wr_cmd_i),
    .we_i      (host_we_i),
    .cfg_i     (cfg),
    .acc_o     (acc),
    .restart_o (restart),
    .phase_o   (phase),
    .commit_o  (commit)
  );

  pix_assembler u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (mem_wr_cmd_i),
    .acc_i     (acc),
    .restart_i (restart),
    .cfg_i     (cfg),
    .phase_i   (phase),
    .data_i    (host_data_i),
    .pix_o     (pix)
  );

  pix_commit #(.ADDR_W(ADDR_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (mem_wr_cmd_i),
    .commit_i (commit),
    .pix_i    (pix),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .data_o   (mem_data_o)
  );

endmodule

// File: rtl/pix_pack_checker.sv
module pix_pack_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_wr_cmd_i,
  input logic [1:0]        color_mode_i,
  input logic              bus16_i,
  input logic              host_we_i,
  input logic [15:0]       host_data_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_data_o
);

  a_r12_no_strobe_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_we_i && mem_wr_cmd_i) |=> !mem_we_o);

  a_r2_wide_write_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && mem_wr_cmd_i && bus16_i) |=> mem_we_o);

  a_r7_wide_565_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && mem_wr_cmd_i && bus16_i && color_mode_i[1]) |=> (mem_data_o == $past(host_data_i)));

  a_r9_addr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_we_i && mem_wr_cmd_i) |=> $stable(mem_addr_o));

  a_r10_idle_cmd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wr_cmd_i |=> (!mem_we_o && $stable(mem_data_o)));

endmodule

bind pix_pack_top pix_pack_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pix_pack_top.sv
module tb_pix_pack_top;

  localparam int unsigned ADDR_W = 17;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mem_wr_cmd_i = 1'b0;
  logic [1:0]        color_mode_i = 2'd0;
  logic              bus16_i = 1'b0;
  logic              host_we_i = 1'b0;
  logic [15:0]       host_data_i = '0;
  logic              mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [15:0]       mem_data_o;

  always #10 clk_i = ~clk_i;

  pix_pack_top #(.ADDR_W(ADDR_W)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // driven configuration
  int drv_mode = 0, drv_wide = 0, drv_cmd = 0;

  // reference model state
  int m_mode = 0, m_wide = 0, m_phase = 0, m_prev = 0, m_cmd_prev = 0, m_addr = 0;
  int e_we = 0, e_addr = 0, e_data = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wid(input int r, input int g, input int b);
    return (r << 12) | ((r >> 3) << 11) | (g << 7) | ((g >> 2) << 5) | (b << 1) | (b >> 3);
  endfunction

  task automatic step(input bit we, input int d);
    int r, g, b, px, bt, nphase;
    bit cm;
    @(negedge clk_i);
    mem_wr_cmd_i = drv_cmd[0];
    color_mode_i = drv_mode[1:0];
    bus16_i      = drv_wide[0];
    host_we_i    = we;
    host_data_i  = d[15:0];
    cm = 0; r = 0; g = 0; b = 0; px = 0;
    if (drv_cmd != 0 && m_cmd_prev == 0) m_addr = 0;
    if (we && drv_cmd != 0) begin
      if (drv_mode != m_mode || drv_wide != m_wide) m_phase = 0;
      m_mode = drv_mode;
      m_wide = drv_wide;
      if (drv_wide != 0) begin
        cm = 1;
        if (drv_mode == 0)      px = wid((d >> 12) & 15, (d >> 8) & 15, (d >> 4) & 15);
        else if (drv_mode == 1) px = wid((d >> 8) & 15, (d >> 4) & 15, d & 15);
        else                    px = d & 16'hFFFF;
      end else begin
        bt = d & 255;
        if (m_phase != 0) cm = 1;
        if (drv_mode == 0) begin
          if (m_phase == 1) px = wid(m_prev >> 4, m_prev & 15, bt >> 4);
          else              px = wid(m_prev & 15, bt >> 4, bt & 15);
          nphase = (m_phase + 1) % 3;
        end else begin
          if (drv_mode == 1) px = wid(m_prev & 15, bt >> 4, bt & 15);
          else               px = (m_prev << 8) | bt;
          nphase = (m_phase + 1) % 2;
        end
        m_phase = nphase;
        m_prev = bt;
      end
    end
    if (drv_cmd == 0) m_phase = 0;
    m_cmd_prev = drv_cmd;
    e_we = cm;
    if (cm) begin
      e_data = px;
      e_addr = m_addr;
      m_addr = (m_addr + 1) % (1 << ADDR_W);
    end
    @(posedge clk_i);
    #1;
    chk({cur_tag, " we"}, int'(mem_we_o), e_we);
    chk({cur_tag, " addr"}, int'(mem_addr_o), e_addr);
    chk({cur_tag, " data"}, int'(mem_data_o), e_data);
  endtask

  task automatic wr(input int d);  step(1, d); endtask
  task automatic idle();           step(0, 0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    #35;
    chk("R1 we in reset", int'(mem_we_o), 0);
    chk("R1 addr in reset", int'(mem_addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle();

    // R3 R8 format A bytes
    cur_tag = "R3"; drv_cmd = 1; drv_mode = 0; drv_wide = 0;
    wr(8'h12); chk("R3 no commit on byte 1", int'(mem_we_o), 0);
    wr(8'h34); chk("R8 pixel 1", int'(mem_data_o), 16'h1106); chk("R9 addr 0", int'(mem_addr_o), 0);
    wr(8'h56); chk("R8 pixel 2", int'(mem_data_o), 16'h42AC); chk("R9 addr 1", int'(mem_addr_o), 1);
    cur_tag = "R12"; idle(); chk("R12 strobe one cycle", int'(mem_we_o), 0);

    // R10 ignored write and dropped partial group
    cur_tag = "R10"; drv_cmd = 0; wr(8'h77); chk("R10 ignored", int'(mem_we_o), 0);
    drv_cmd = 1; wr(8'h12); drv_cmd = 0; idle(); drv_cmd = 1;
    wr(8'h12); chk("R10 restart no commit", int'(mem_we_o), 0);
    wr(8'h34); chk("R10 restart pixel", int'(mem_data_o), 16'h1106); chk("R9 addr back to 0", int'(mem_addr_o), 0);

    // R11 mode change mid group
    cur_tag = "R11"; wr(8'h12); drv_mode = 2;
    wr(8'hAB); chk("R11 new group no commit", int'(mem_we_o), 0);
    wr(8'hCD); chk("R7 565 bytes", int'(mem_data_o), 16'hABCD);

    // R5 format B bytes
    cur_tag = "R5"; drv_mode = 1;
    wr(8'hF7); chk("R5 no commit byte 1", int'(mem_we_o), 0);
    wr(8'h9C); chk("R5 pixel", int'(mem_data_o), 16'h74D9);

    // R2 R4 R6 R7 wide writes, back to back
    cur_tag = "R2"; drv_wide = 1; drv_mode = 0;
    wr(16'h123F); chk("R4 A wide", int'(mem_data_o), 16'h1106);
    drv_mode = 1; wr(16'hF456); chk("R6 B wide", int'(mem_data_o), 16'h42AC);
    drv_mode = 3; wr(16'hBEEF); chk("R7 565 wide", int'(mem_data_o), 16'hBEEF);
    chk("R2 strobe", int'(mem_we_o), 1);

    // random mix
    cur_tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 23) == 0) drv_mode = $urandom % 4;
      if (($urandom % 29) == 0) drv_wide = $urandom % 2;
      if (($urandom % 37) == 0) drv_cmd = (($urandom % 4) != 0);
      step(($urandom % 4) != 0, $urandom % 65536);
    end
    drv_cmd = 0; idle();
    finish_run();
  end

endmodule